// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode/register read, execute, memory, write-back) handles dependencies between the instructions it holds. The first input set describes the instruction now in execute: its two source register numbers. The second and third sets describe the two older instructions ahead of it: their destination register numbers and register-write flags. From these the block steers each ALU operand to the memory-stage result, the write-back-stage result or the register file value. A result computed in a later stage reaches a dependent instruction before it is written to the register file.

A load in execute whose destination is a source of the instruction in decode cannot be covered by forwarding. The block raises a stall for exactly that case. The stall holds the program counter and the fetch/decode register, and it turns the execute-stage entry into a bubble. Branches are predicted not taken. When a branch resolves as taken, the block raises a flush that turns the two younger, wrongly fetched instructions into bubbles. A separate bubble output tells the pipeline when to clear the register-write and memory-write flags that travel with the execute-stage entry.

All outputs are combinational functions of the current pipeline-register contents. They are consumed in the same cycle by the operand multiplexers and by the enables of the pipeline registers.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (take the memory-stage result) when the memory-stage instruction writes a register, its destination is nonzero, and its destination equals that operand's source register.
- R2: An operand select is 2'b01 (take the write-back-stage result) when the write-back-stage instruction writes a nonzero destination equal to the operand's source and the R1 condition does not hold.
- R3: When both the memory stage and the write-back stage match the same source register, the select is 2'b10; the younger result wins.
- R4: Register 0 is never forwarded. A source of 0, an unmatched source, or a match whose write flag is low gives select 2'b00 (register file).
- R5: The stall output is 1 when the execute-stage instruction is a load with a nonzero destination equal to either source register of the decode-stage instruction, and no flush is active.
- R6: A load whose destination is register 0, or a non-load instruction, never causes a stall.
- R7: The flush output is 1 exactly when a branch resolves this cycle with outcome taken. A branch that resolves not taken causes no flush.
- R8: Flush takes precedence over stall, so the two are never high together; a load-use match on a wrong-path instruction is dropped.
- R9: The bubble output, which clears the register-write and memory-write flags entering execute, equals stall OR flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the embedded checks |
| ex_src_a | input | REG_W | First source register of the instruction in execute |
| ex_src_b | input | REG_W | Second source register of the instruction in execute |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads memory |
| mem_dst | input | REG_W | Destination register of the instruction in the memory stage |
| mem_wr_en | input | 1 | Instruction in the memory stage writes a register |
| wb_dst | input | REG_W | Destination register of the instruction in write-back |
| wb_wr_en | input | 1 | Instruction in write-back writes a register |
| dec_src_a | input | REG_W | First source register of the instruction in decode |
| dec_src_b | input | REG_W | Second source register of the instruction in decode |
| br_done | input | 1 | A branch resolves this cycle |
| br_taken | input | 1 | Outcome of the resolving branch |
| sel_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory stage |
| sel_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register |
| flush | output | 1 | Turn fetch/decode and execute entries into bubbles |
| bubble | output | 1 | Clear control flags of the entry entering execute |

## Verification
The bench sweeps every combination of source, destination and write flag on a 3-bit register file. It therefore reaches the double-match case: a design that checked write-back first would hand an operand a stale value (R3). Register 0 gets its own attention, because a design that forwarded it would feed a discarded result into an instruction that reads the hardwired zero. The load-use sweep covers loads that match only the second decode source and loads into register 0; missing the first would let a dependent instruction read the old value, and the second would cost a needless cycle. Every load-use pattern is also repeated with a taken branch resolving. A design that stalled and flushed together would freeze a wrong-path instruction in decode.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    OPND_RF  = 2'b00,
    OPND_WB  = 2'b01,
    OPND_MEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/operand_route.sv
module operand_route
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output opnd_src_e        sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic mem_hit, wb_hit;

  assign mem_hit = mem_wr_en && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign wb_hit  = wb_wr_en  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  always_comb begin
    if (mem_hit)      sel = OPND_MEM;
    else if (wb_hit)  sel = OPND_WB;
    else              sel = OPND_RF;
  end

  // R3
  mem_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && wb_wr_en && mem_dst == wb_dst && mem_dst == src && src != ZERO_REG)
      |-> (sel == OPND_MEM));

  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (src == ZERO_REG) |-> (sel == OPND_RF));

  // R4
  no_writer_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_wr_en && !wb_wr_en) |-> (sel == OPND_RF));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ld_dst,
  input  logic             ld_active,
  input  logic [REG_W-1:0] use_a,
  input  logic [REG_W-1:0] use_b,
  input  logic             kill,
  output logic             hold
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dep;

  assign dep  = (ld_dst == use_a) || (ld_dst == use_b);
  assign hold = ld_active && (ld_dst != ZERO_REG) && dep && !kill;

  // R6
  load_only_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> (ld_active && ld_dst != ZERO_REG));

  // R8
  kill_wins_chk: assert property (@(posedge clk) disable iff (rst)
    kill |-> !hold);
endmodule

// File: rtl/branch_redirect.sv
module branch_redirect (
  input  logic clk,
  input  logic rst,
  input  logic resolved,
  input  logic taken,
  output logic redirect
);
  assign redirect = resolved & taken;

  // R7
  not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (resolved && !taken) |-> !redirect);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !resolved |-> !redirect);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             br_done,
  input  logic             br_taken,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall,
  output logic             flush,
  output logic             bubble
);
  localparam int NUM_OPND = 2;

  logic [REG_W-1:0] srcs [NUM_OPND];
  opnd_src_e        sels [NUM_OPND];

  assign srcs[0] = ex_src_a;
  assign srcs[1] = ex_src_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    operand_route #(.REG_W(REG_W)) u_route (
      .clk       (clk),
      .rst       (rst),
      .src       (srcs[g]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (sels[g])
    );
  end

  assign sel_a = sels[0];
  assign sel_b = sels[1];

  branch_redirect u_redirect (
    .clk      (clk),
    .rst      (rst),
    .resolved (br_done),
    .taken    (br_taken),
    .redirect (flush)
  );

  load_use_detect #(.REG_W(REG_W)) u_lu (
    .clk       (clk),
    .rst       (rst),
    .ld_dst    (ex_dst),
    .ld_active (ex_is_load),
    .use_a     (dec_src_a),
    .use_b     (dec_src_b),
    .kill      (flush),
    .hold      (stall)
  );

  assign bubble = stall | flush;

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stall && flush));

  // R9
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (stall || flush) |-> bubble);

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_done && !ex_is_load) |-> !bubble);
endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int NREG = 1 << RW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] ex_src_a = '0, ex_src_b = '0, ex_dst = '0;
  logic ex_is_load = 1'b0;
  logic [RW-1:0] mem_dst = '0, wb_dst = '0;
  logic mem_wr_en = 1'b0, wb_wr_en = 1'b0;
  logic [RW-1:0] dec_src_a = '0, dec_src_b = '0;
  logic br_done = 1'b0, br_taken = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic stall, flush, bubble;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit #(.REG_W(RW)) u0 (
    .clk(clk), .rst(rst),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en), .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .br_done(br_done), .br_taken(br_taken),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall), .flush(flush), .bubble(bubble)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(int s, int md, int mw, int wd, int ww);
    if (mw == 1 && md != 0 && md == s) return 2;
    if (ww == 1 && wd != 0 && wd == s) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int s, int md, int mw, int wd, int ww);
    bit mh = (mw == 1 && md != 0 && md == s);
    bit wh = (ww == 1 && wd != 0 && wd == s);
    if (s == 0) return "R4";
    if (mh && wh) return "R3";
    if (mh) return "R1";
    if (wh) return "R2";
    return "R4";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // reset state with idle inputs
    chk("R4 reset sel_a", sel_a, 0);
    chk("R4 reset sel_b", sel_b, 0);
    chk("R6 reset stall", stall, 0);
    chk("R7 reset flush", flush, 0);
    chk("R9 reset bubble", bubble, 0);
    @(negedge clk);
    rst = 1'b0;

    // forwarding sweep: R1 R2 R3 R4
    for (int s = 0; s < NREG; s++)
      for (int md = 0; md < NREG; md++)
        for (int mw = 0; mw < 2; mw++)
          for (int wd = 0; wd < NREG; wd++)
            for (int ww = 0; ww < 2; ww++) begin
              @(negedge clk);
              ex_src_a  = RW'(s);
              ex_src_b  = RW'(NREG - 1 - s);
              mem_dst   = RW'(md);
              mem_wr_en = mw[0];
              wb_dst    = RW'(wd);
              wb_wr_en  = ww[0];
              #1;
              chk({sel_tag(s, md, mw, wd, ww), " sel_a"}, sel_a, exp_sel(s, md, mw, wd, ww));
              chk({sel_tag(NREG-1-s, md, mw, wd, ww), " sel_b"}, sel_b,
                  exp_sel(NREG-1-s, md, mw, wd, ww));
            end

    mem_wr_en = 1'b0;
    wb_wr_en  = 1'b0;

    // load-use and branch sweep: R5 R6 R7 R8 R9
    for (int ld = 0; ld < NREG; ld++)
      for (int lm = 0; lm < 2; lm++)
        for (int ra = 0; ra < NREG; ra++)
          for (int rb = 0; rb < NREG; rb++)
            for (int br = 0; br < 4; br++) begin
              int e_fl, e_st;
              @(negedge clk);
              ex_dst     = RW'(ld);
              ex_is_load = lm[0];
              dec_src_a  = RW'(ra);
              dec_src_b  = RW'(rb);
              br_done    = br[0];
              br_taken   = br[1];
              #1;
              e_fl = (br == 3) ? 1 : 0;
              e_st = (lm == 1 && ld != 0 && (ld == ra || ld == rb) && e_fl == 0) ? 1 : 0;
              chk("R7 flush", flush, e_fl);
              if (lm == 1 && ld != 0 && (ld == ra || ld == rb) && e_fl == 1)
                chk("R8 stall suppressed", stall, e_st);
              else if (lm == 0 || ld == 0)
                chk("R6 stall", stall, e_st);
              else
                chk("R5 stall", stall, e_st);
              chk("R9 bubble", bubble, (e_st | e_fl));
            end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule